// File: doc/BRIEF.md
# Prioritised Interrupt Collector with Test Injection

This block gathers up to fifteen interrupt request lines into a single pending word and presents the processor with one 4-bit number: the highest-numbered source that is both pending and allowed by the mask. A request is captured when its input line rises. The pending bit then stays set until software removes it, or until the processor acknowledges that level.

Software reaches the block through a small synchronous register port. The mask word and a test-control word can be written and read back. The pending word can be read. Two write-only addresses act on the pending word one bit at a time: one removes the bits written as 1, and the other injects them. Injection has effect only while the enable bit in the test-control word is set, so a stray write cannot raise a false interrupt in normal use.

Top module: `irqc_top`

## Requirements
- R1: After reset, every pending bit is 0, mask bits 1 to 15 are 1 (read value 0xFFFE), the test enable (bit 19 of address 4) is 0, and the level output is 0.
- R2: A 0-to-1 change on source line n (n = 1..15), sampled on a clock edge, sets pending bit n on that edge. A line that stays high sets nothing further.
- R3: A write to address 2 clears every pending bit whose data bit is 1. Bits written as 0 keep their value.
- R4: While the test enable is 1, a write to address 3 sets every pending bit n (n = 1..15) whose data bit is 1.
- R5: While the test enable is 0, a write to address 3 changes no pending bit.
- R6: A mask bit of 1 keeps its source out of the level output but does not stop the pending bit from being recorded. A mask bit of 0 lets the source through. A write to address 1 loads mask bits 1..15.
- R7: The level output is the largest n whose pending bit is 1 and whose mask bit is 0, or 0 when no such n exists.
- R8: An acknowledge with level n (n = 1..15) clears pending bit n on the sampling edge. An acknowledge with level 0 changes nothing.
- R9: A rising edge on source n in the same cycle as a clear of bit n (by acknowledge or by a write to address 2) leaves bit n set.
- R10: The read data returns the pending word at address 0, the mask word at address 1, and the test enable in bit 19 at address 4. Bit 0 of every word reads 0, and addresses 2, 3 and any others read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | 15 | Source request lines; bit n is source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Highest unmasked pending source, 0 if none |

## Verification
A corrupted pending or mask bit shows on the level output as soon as it belongs to the highest enabled source. A lower-ranked corruption stays hidden from the level until the sources above it are cleared. The pending and mask words are readable, so the bench reads them back every cycle and compares the whole word. Any wrong bit then shows up one cycle after the edge that caused it, and does not wait until it wins the priority. The test-enable bit is observed both directly through its read address and indirectly through the effect of injection writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register port address map
    typedef enum logic [2:0] {
        RA_PEND  = 3'd0,
        RA_MASK  = 3'd1,
        RA_CLEAR = 3'd2,
        RA_FORCE = 3'd3,
        RA_TEST  = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int NUM_SRC = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   line_i,
    output logic [NUM_SRC:0]   rise_o
);

    logic [NUM_SRC:1] prev_d, prev_q;

    always_comb begin
        prev_d = line_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o[0] = 1'b0;

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_rise
        assign rise_o[s] = line_i[s] & ~prev_q[s];
    end

endmodule

// File: rtl/irqc_lvl2vec.sv
module irqc_lvl2vec #(
    parameter int NUM_SRC = 15,
    localparam int LVL_W  = $clog2(NUM_SRC + 1)
) (
    input  logic             valid_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [NUM_SRC:0] vec_o
);

    assign vec_o[0] = 1'b0;

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_dec
        assign vec_o[s] = valid_i && (level_i == LVL_W'(s));
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_SRC = 15,
    localparam int LVL_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:0] req_i,
    output logic [LVL_W-1:0] level_o
);

    // Scan upward: the last hit is the highest-numbered request
    always_comb begin
        level_o = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (req_i[s]) level_o = LVL_W'(s);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int NUM_SRC  = 15,
    parameter int DATA_W   = 32,
    parameter int TEST_BIT = 19,
    localparam int LVL_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_src_i,
    input  logic               reg_wr_i,
    input  logic [2:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic               ack_valid_i,
    input  logic [LVL_W-1:0]   ack_level_i,
    output logic [LVL_W-1:0]   irq_level_o
);
    import irqc_pkg::*;

    localparam logic [NUM_SRC:0] SRC_BITS = {{NUM_SRC{1'b1}}, 1'b0};

    typedef struct packed {
        logic [NUM_SRC:0] pending;
        logic [NUM_SRC:0] mask;
        logic             test_en;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC:0] rise_vec;
    logic [NUM_SRC:0] ack_vec;
    logic [NUM_SRC:0] clr_vec;
    logic [NUM_SRC:0] frc_vec;
    logic [NUM_SRC:0] live_vec;
    logic             wr_mask, wr_clear, wr_force, wr_test;

    irqc_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (irq_src_i),
        .rise_o (rise_vec)
    );

    irqc_lvl2vec #(.NUM_SRC(NUM_SRC)) u_ack (
        .valid_i (ack_valid_i),
        .level_i (ack_level_i),
        .vec_o   (ack_vec)
    );

    assign live_vec = st_q.pending & ~st_q.mask;

    irqc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .req_i   (live_vec),
        .level_o (irq_level_o)
    );

    // Next-state computation
    always_comb begin
        st_d     = st_q;
        wr_mask  = reg_wr_i && (reg_addr_i == RA_MASK);
        wr_clear = reg_wr_i && (reg_addr_i == RA_CLEAR);
        wr_force = reg_wr_i && (reg_addr_i == RA_FORCE);
        wr_test  = reg_wr_i && (reg_addr_i == RA_TEST);

        clr_vec = ack_vec;
        if (wr_clear) clr_vec = clr_vec | reg_wdata_i[NUM_SRC:0];

        frc_vec = '0;
        if (wr_force && st_q.test_en) frc_vec = reg_wdata_i[NUM_SRC:0];

        // sets (edges, injection) dominate clears
        st_d.pending = ((st_q.pending & ~clr_vec) | rise_vec | frc_vec) & SRC_BITS;

        if (wr_mask) st_d.mask    = reg_wdata_i[NUM_SRC:0] & SRC_BITS;
        if (wr_test) st_d.test_en = reg_wdata_i[TEST_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pending <= '0;
            st_q.mask    <= SRC_BITS;
            st_q.test_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read port
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            RA_PEND: reg_rdata_o[NUM_SRC:0] = st_q.pending;
            RA_MASK: reg_rdata_o[NUM_SRC:0] = st_q.mask;
            RA_TEST: reg_rdata_o[TEST_BIT]  = st_q.test_en;
            default: reg_rdata_o = '0;
        endcase
    end

    // Assertions
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_vec) |=> ((st_q.pending & $past(rise_vec)) == $past(rise_vec)));

    p_force_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.test_en) |=> ((st_q.pending & ~$past(st_q.pending) & ~$past(rise_vec)) == '0));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_vec & ~rise_vec & ~frc_vec)) |=>
            ((st_q.pending & $past(ack_vec & ~rise_vec & ~frc_vec)) == '0));

    p_level_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o != '0) |-> (live_vec[irq_level_o] && ((live_vec >> irq_level_o) == 1)));

    p_level_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_vec == '0) |-> (irq_level_o == '0));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mask) |=> $stable(st_q.mask));

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    localparam int NS = 15;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [NS:1]  irq_src_i;
    logic         reg_wr_i;
    logic [2:0]   reg_addr_i;
    logic [31:0]  reg_wdata_i;
    logic [31:0]  reg_rdata_o;
    logic         ack_valid_i;
    logic [3:0]   ack_level_i;
    logic [3:0]   irq_level_o;

    always #5 clk = ~clk;

    irqc_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (irq_src_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .ack_valid_i (ack_valid_i),
        .ack_level_i (ack_level_i),
        .irq_level_o (irq_level_o)
    );

    // Behavioural reference
    bit [15:0] m_pend, m_mask;
    bit        m_test;
    bit [NS:1] m_prev;
    bit        m_live = 0;
    int        n_cmp = 0, n_bad = 0;
    string     cur_req = "R1";
    bit        done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = 16'hFFFE; m_test = 0; m_prev = '0;
        end else begin
            bit [15:0] np;
            np = m_pend;
            for (int s = 1; s <= NS; s++) begin
                bit rise, clr, frc;
                rise = irq_src_i[s] && !m_prev[s];
                clr  = (reg_wr_i && reg_addr_i == 3'd2 && reg_wdata_i[s]) ||
                       (ack_valid_i && ack_level_i == s);
                frc  = reg_wr_i && reg_addr_i == 3'd3 && m_test && reg_wdata_i[s];
                if (rise || frc)  np[s] = 1'b1;
                else if (clr)     np[s] = 1'b0;
            end
            if (reg_wr_i && reg_addr_i == 3'd1) m_mask = reg_wdata_i[15:0] & 16'hFFFE;
            if (reg_wr_i && reg_addr_i == 3'd4) m_test = reg_wdata_i[19];
            m_pend = np;
            m_prev = irq_src_i;
        end
        m_live = 1;
    end

    function automatic int exp_level();
        int l = 0;
        for (int s = 1; s <= NS; s++) if (m_pend[s] && !m_mask[s]) l = s;
        return l;
    endfunction

    function automatic bit [31:0] exp_rdata();
        case (reg_addr_i)
            3'd0:    return {16'h0, m_pend};
            3'd1:    return {16'h0, m_mask};
            3'd4:    return 32'(m_test) << 19;
            default: return 32'h0;
        endcase
    endfunction

    // Compare on every falling edge; inputs change 1 ns later
    always @(negedge clk) begin
        if (m_live && !done) begin
            n_cmp++;
            if (irq_level_o !== 4'(exp_level())) begin
                n_bad++;
                $display("FAIL %s level act %0d exp %0d", cur_req, irq_level_o, exp_level());
            end
            n_cmp++;
            if (reg_rdata_o !== exp_rdata()) begin
                n_bad++;
                $display("FAIL %s rdata@%0d act %h exp %h", cur_req, reg_addr_i, reg_rdata_o, exp_rdata());
            end
        end
    end

    task automatic step(input bit [NS:1] src, input bit wr, input bit [2:0] a,
                        input bit [31:0] wd, input bit av, input bit [3:0] al);
        @(negedge clk); #1;
        irq_src_i = src; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
        ack_valid_i = av; ack_level_i = al;
    endtask

    task automatic idle(input bit [NS:1] src, input bit [2:0] a);
        step(src, 0, a, 0, 0, 0);
    endtask

    function automatic bit [NS:1] sb(input int n);
        return NS'(1) << (n - 1);
    endfunction

    initial begin
        bit [NS:1] s;
        rst_n = 0; irq_src_i = '0; reg_wr_i = 0; reg_addr_i = 0;
        reg_wdata_i = 0; ack_valid_i = 0; ack_level_i = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset values of every readable word
        cur_req = "R1";
        idle('0, 3'd0); idle('0, 3'd1); idle('0, 3'd4);
        // R2: rising edge records pending while masked (R6)
        cur_req = "R2";
        s = sb(3);
        idle(s, 3'd0); idle(s, 3'd0);
        // R6: open the mask, then hide source 9
        cur_req = "R6";
        step(s, 1, 3'd1, 32'h0, 0, 0); idle(s, 3'd0);
        cur_req = "R7";
        s |= sb(9); idle(s, 3'd0); idle(s, 3'd0);
        cur_req = "R6";
        step(s, 1, 3'd1, 32'h0200, 0, 0); idle(s, 3'd1); idle(s, 3'd0);
        // R3: one-hot clear, others untouched
        cur_req = "R3";
        step(s, 1, 3'd2, 32'h0008, 0, 0); idle(s, 3'd0);
        step(s, 1, 3'd2, 32'h0200, 0, 0); idle(s, 3'd0);
        // R2: held-high lines do not re-trigger
        cur_req = "R2";
        idle(s, 3'd0); idle(s, 3'd0);
        step('0, 1, 3'd1, 32'h0, 0, 0);
        s = '0;
        // R5: injection blocked without the test enable
        cur_req = "R5";
        step(s, 1, 3'd3, 32'h1010, 0, 0); idle(s, 3'd0);
        // R4: enable test, inject 5 and 12
        cur_req = "R4";
        step(s, 1, 3'd4, 32'h0008_0000, 0, 0); idle(s, 3'd4);
        step(s, 1, 3'd3, 32'h1020, 0, 0); idle(s, 3'd0);
        // R8: acknowledge top level, then level 0 no-op
        cur_req = "R8";
        step(s, 0, 3'd0, 0, 1, 4'd12); idle(s, 3'd0);
        step(s, 0, 3'd0, 0, 1, 4'd0); idle(s, 3'd0);
        step(s, 0, 3'd0, 0, 1, 4'd5); idle(s, 3'd0);
        // R9: edge beats acknowledge and clear write in the same cycle
        cur_req = "R9";
        step(sb(7), 0, 3'd0, 0, 0, 0); step('0, 0, 3'd0, 0, 0, 0);
        step(sb(7), 0, 3'd0, 0, 1, 4'd7); idle('0, 3'd0);
        step(sb(7), 1, 3'd2, 32'h0080, 0, 0); idle(sb(7), 3'd0);
        // R10: write-only addresses read 0; bit 0 never set
        cur_req = "R10";
        step('0, 1, 3'd3, 32'hFFFF_FFFF, 0, 0);
        idle('0, 3'd0); idle('0, 3'd2); idle('0, 3'd3); idle('0, 3'd7);
        step('0, 1, 3'd1, 32'hFFFF_FFFF, 0, 0); idle('0, 3'd1);
        // Mixed traffic across all requirements
        cur_req = "R7";
        for (int i = 0; i < 600; i++) begin
            bit [31:0] r = $urandom;
            step(NS'($urandom), r[0] & r[1], 3'(r[4:2] % 5), $urandom,
                 r[5], 4'(r[9:6]));
        end
        idle('0, 3'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog act timeout exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule